// File: doc/BRIEF.md
# Randomized Memory Trace Generator

This block takes the place of a processor core at the edge of a memory system under test. Once started with a seed, it produces a reproducible pseudo-random mix of loads, stores and ordering fences. Loads and stores go out on a tagged request port, and the generator matches each response back to its request. Several requests can be in flight at once, and the memory side may answer them in any order.

For every accepted request the generator emits an issue record, and for every matched response it emits a response record. Each record carries the request number, the core number, the data, and a timestamp taken from a free-running cycle counter. Together these records form a trace that an external consistency checker can judge. Store values are unique across all generator instances in a run, and addresses come from a small pool that all instances share, so different cores contend for the same locations. A request left unanswered for too long raises a sticky error flag. When all operations have been generated and every response has returned, `done` rises.

Top module: `memtrace_gen`

## Requirements
- R1: The random source is a 32-bit register loaded from `seed` when a run starts (a zero seed loads 1). It advances once per consumed operation as next = (s >> 1) XOR (s[0] ? 0x80200003 : 0). The same seed therefore always yields the same request sequence.
- R2: The operation is decoded from bits [1:0] of the current random word: 0 or 1 is a load, 2 is a store, 3 is a fence. The address is bits [POOL_W+1:2] of that word multiplied by ADDR_STRIDE. `req_store` and the issue-record kind are 1 for stores.
- R3: Requests are numbered from 0 in issue order within each run. `req_tag` is the low TAG_W bits of that number. A request is not offered while its tag is still outstanding. An offered request stays unchanged until `req_ready` accepts it.
- R4: The k-th store of a run (k counted from 0) writes INST_ID + (k+1)*NUM_INST, so no two instances can produce the same value. Loads drive `req_wdata` as 0.
- R5: A fence issues no request and takes no request number. It is consumed only in a cycle with no request outstanding, so no later request is accepted before every earlier one has responded.
- R6: One cycle after a request handshake, the issue record is valid with that request's number, kind, address and data. Its timestamp is the cycle count of the handshake cycle, where the count starts at 0 when reset is released and increases by one every clock.
- R7: One cycle after `rsp_valid` carries the tag of an outstanding request, the response record is valid with that request's number, `rsp_data`, and the cycle count of the response cycle. Responses may arrive in any order.
- R8: A response whose tag is not outstanding is ignored: no response record is produced.
- R9: `timeout_err` rises at the TIMEOUT-th clock edge after a request is accepted, if that request is still unanswered. The flag then stays set until reset.
- R10: `done` rises once NUM_OPS operations have been consumed and no request is outstanding, and no request is offered while it is set. A new run starts on `start` only when no run is in progress, and starting a run clears `done`.
- R11: `rec_core` always equals INST_ID.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a run (accepted only when no run is in progress) |
| seed | input | 32 | Seed for the random source |
| req_valid | output | 1 | Request offered |
| req_ready | input | 1 | Memory accepts the request |
| req_tag | output | TAG_W | Tag of the offered request |
| req_store | output | 1 | 1 = store, 0 = load |
| req_addr | output | ADDR_W | Request address |
| req_wdata | output | DATA_W | Store value (0 for loads) |
| rsp_valid | input | 1 | Response present |
| rsp_tag | input | TAG_W | Tag of the response |
| rsp_data | input | DATA_W | Response data |
| iss_rec_valid | output | 1 | Issue record valid |
| iss_rec_id | output | OPS_W | Request number |
| iss_rec_store | output | 1 | Record kind, 1 = store |
| iss_rec_addr | output | ADDR_W | Address of the issued request |
| iss_rec_data | output | DATA_W | Store value or 0 |
| iss_rec_time | output | TS_W | Cycle count of the handshake |
| rsp_rec_valid | output | 1 | Response record valid |
| rsp_rec_id | output | OPS_W | Request number matched by tag |
| rsp_rec_data | output | DATA_W | Returned data |
| rsp_rec_time | output | TS_W | Cycle count of the response |
| rec_core | output | CORE_W | Core number stamped on records |
| timeout_err | output | 1 | Sticky response timeout |
| done | output | 1 | Run complete, nothing outstanding |

## Verification
A corrupted random word or store counter shows up at the very next request handshake as a wrong address, kind or value, because every accepted request is compared against an independent model of the seed sequence. A faulty tag table appears within one cycle of a response, either as a response record carrying the wrong request number or as a missing record. It can also appear as a request offered on a tag that is still busy. Age-counter faults show up as `timeout_err` moving one edge early or late against a deliberately unanswered request. An error in the outstanding count shows up either as `done` never rising or as a request slipping past a fence.

// File: rtl/mtg_pkg.sv
package mtg_pkg;

    typedef enum logic [1:0] {
        OP_LOAD_A = 2'd0,
        OP_LOAD_B = 2'd1,
        OP_STORE  = 2'd2,
        OP_FENCE  = 2'd3
    } op_e;

    localparam logic [31:0] RNG_TAPS = 32'h8020_0003;

    function automatic logic [31:0] rng_advance(input logic [31:0] s);
        return (s >> 1) ^ (s[0] ? RNG_TAPS : 32'h0);
    endfunction

endpackage

// File: rtl/mtg_opgen.sv
module mtg_opgen
    import mtg_pkg::*;
#(
    parameter int POOL_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [31:0]       seed,
    input  logic              step,
    output op_e               op_o,
    output logic [POOL_W-1:0] pool_idx_o
);

    typedef struct packed {
        logic [31:0] rng;
    } gen_t;

    gen_t g_d, g_q;

    always_comb begin
        g_d = g_q;
        if (load) begin
            g_d.rng = (seed == 32'h0) ? 32'h1 : seed;
        end else if (step) begin
            g_d.rng = rng_advance(g_q.rng);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            g_q <= '{rng: 32'h1};
        end else begin
            g_q <= g_d;
        end
    end

    assign op_o       = op_e'(g_q.rng[1:0]);
    assign pool_idx_o = g_q.rng[2 +: POOL_W];

endmodule

// File: rtl/mtg_slots.sv
module mtg_slots #(
    parameter int TAG_W   = 2,
    parameter int ID_W    = 7,
    parameter int TIMEOUT = 1024
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   alloc,
    input  logic [TAG_W-1:0]       alloc_tag,
    input  logic [ID_W-1:0]        alloc_id,
    input  logic                   rsp_valid,
    input  logic [TAG_W-1:0]       rsp_tag,
    output logic [(1<<TAG_W)-1:0]  busy_o,
    output logic                   hit_o,
    output logic [ID_W-1:0]        hit_id_o,
    output logic                   expired_o
);

    localparam int NSLOT = 1 << TAG_W;
    localparam int AGE_W = $clog2(TIMEOUT + 1);
    localparam logic [AGE_W-1:0] AGE_LAST = AGE_W'(TIMEOUT - 1);

    typedef struct packed {
        logic             busy;
        logic [ID_W-1:0]  id;
        logic [AGE_W-1:0] age;
    } slot_t;

    slot_t [NSLOT-1:0] sl_d, sl_q;
    logic              expired_c;

    always_comb begin
        logic freeing;
        sl_d      = sl_q;
        expired_c = 1'b0;
        for (int i = 0; i < NSLOT; i++) begin
            freeing = rsp_valid && (rsp_tag == TAG_W'(i)) && sl_q[i].busy;
            if (sl_q[i].busy && !freeing && sl_q[i].age == AGE_LAST) begin
                expired_c = 1'b1;
            end
            if (freeing) begin
                sl_d[i].busy = 1'b0;
            end else if (sl_q[i].busy && sl_q[i].age != AGE_LAST) begin
                sl_d[i].age = sl_q[i].age + 1'b1;
            end
            if (alloc && alloc_tag == TAG_W'(i)) begin
                sl_d[i].busy = 1'b1;
                sl_d[i].id   = alloc_id;
                sl_d[i].age  = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sl_q <= '0;
        end else begin
            sl_q <= sl_d;
        end
    end

    for (genvar g = 0; g < NSLOT; g++) begin : g_busy
        assign busy_o[g] = sl_q[g].busy;
    end

    assign hit_o     = rsp_valid && sl_q[rsp_tag].busy;
    assign hit_id_o  = sl_q[rsp_tag].id;
    assign expired_o = expired_c;

endmodule

// File: rtl/memtrace_gen.sv
module memtrace_gen
    import mtg_pkg::*;
#(
    parameter int INST_ID     = 0,
    parameter int NUM_INST    = 2,
    parameter int NUM_OPS     = 64,
    parameter int TAG_W       = 2,
    parameter int POOL_W      = 2,
    parameter int ADDR_STRIDE = 8,
    parameter int ADDR_W      = 32,
    parameter int DATA_W      = 32,
    parameter int TS_W        = 32,
    parameter int TIMEOUT     = 1024,
    localparam int OPS_W      = $clog2(NUM_OPS + 1),
    localparam int CORE_W     = (NUM_INST > 1) ? $clog2(NUM_INST) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [31:0]       seed,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [TAG_W-1:0]  req_tag,
    output logic              req_store,
    output logic [ADDR_W-1:0] req_addr,
    output logic [DATA_W-1:0] req_wdata,
    input  logic              rsp_valid,
    input  logic [TAG_W-1:0]  rsp_tag,
    input  logic [DATA_W-1:0] rsp_data,
    output logic              iss_rec_valid,
    output logic [OPS_W-1:0]  iss_rec_id,
    output logic              iss_rec_store,
    output logic [ADDR_W-1:0] iss_rec_addr,
    output logic [DATA_W-1:0] iss_rec_data,
    output logic [TS_W-1:0]   iss_rec_time,
    output logic              rsp_rec_valid,
    output logic [OPS_W-1:0]  rsp_rec_id,
    output logic [DATA_W-1:0] rsp_rec_data,
    output logic [TS_W-1:0]   rsp_rec_time,
    output logic [CORE_W-1:0] rec_core,
    output logic              timeout_err,
    output logic              done
);

    localparam int NSLOT = 1 << TAG_W;

    typedef struct packed {
        logic              run;
        logic              fin;
        logic              err;
        logic [OPS_W-1:0]  ops;
        logic [OPS_W-1:0]  nid;
        logic [DATA_W-1:0] sval;
        logic [TS_W-1:0]   cyc;
        logic              iv;
        logic [OPS_W-1:0]  iid;
        logic              ist;
        logic [ADDR_W-1:0] iaddr;
        logic [DATA_W-1:0] idata;
        logic [TS_W-1:0]   itime;
        logic              rv;
        logic [OPS_W-1:0]  rid;
        logic [DATA_W-1:0] rdata;
        logic [TS_W-1:0]   rtime;
    } gen_st_t;

    gen_st_t st_d, st_q;

    op_e               cur_op;
    logic [POOL_W-1:0] pool_idx;
    logic [NSLOT-1:0]  busy;
    logic              hit;
    logic [OPS_W-1:0]  hit_id;
    logic              expired;

    logic              ops_left;
    logic              any_busy;
    logic [TAG_W-1:0]  cur_tag;
    logic              is_store;
    logic              is_fence;
    logic              offer;
    logic              fire;
    logic              fence_go;
    logic              take_seed;
    logic [ADDR_W-1:0] addr_c;
    logic [DATA_W-1:0] wdata_c;

    mtg_opgen #(
        .POOL_W (POOL_W)
    ) u_opgen (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (take_seed),
        .seed       (seed),
        .step       (fire || fence_go),
        .op_o       (cur_op),
        .pool_idx_o (pool_idx)
    );

    mtg_slots #(
        .TAG_W   (TAG_W),
        .ID_W    (OPS_W),
        .TIMEOUT (TIMEOUT)
    ) u_slots (
        .clk       (clk),
        .rst_n     (rst_n),
        .alloc     (fire),
        .alloc_tag (cur_tag),
        .alloc_id  (st_q.nid),
        .rsp_valid (rsp_valid),
        .rsp_tag   (rsp_tag),
        .busy_o    (busy),
        .hit_o     (hit),
        .hit_id_o  (hit_id),
        .expired_o (expired)
    );

    always_comb begin
        ops_left  = st_q.ops < OPS_W'(NUM_OPS);
        any_busy  = |busy;
        cur_tag   = st_q.nid[TAG_W-1:0];
        is_store  = (cur_op == OP_STORE);
        is_fence  = (cur_op == OP_FENCE);
        offer     = st_q.run && ops_left && !is_fence && !busy[cur_tag];
        fire      = offer && req_ready;
        fence_go  = st_q.run && ops_left && is_fence && !any_busy;
        take_seed = start && !st_q.run;
        addr_c    = ADDR_W'(32'(pool_idx) * ADDR_STRIDE);
        wdata_c   = is_store ? st_q.sval : '0;

        st_d     = st_q;
        st_d.cyc = st_q.cyc + 1'b1;
        st_d.iv  = 1'b0;
        st_d.rv  = 1'b0;

        if (take_seed) begin
            st_d.run  = 1'b1;
            st_d.fin  = 1'b0;
            st_d.ops  = '0;
            st_d.nid  = '0;
            st_d.sval = DATA_W'(INST_ID + NUM_INST);
        end else if (st_q.run && !ops_left && !any_busy) begin
            st_d.run = 1'b0;
            st_d.fin = 1'b1;
        end

        if (fire || fence_go) begin
            st_d.ops = st_q.ops + 1'b1;
        end

        if (fire) begin
            st_d.nid   = st_q.nid + 1'b1;
            st_d.iv    = 1'b1;
            st_d.iid   = st_q.nid;
            st_d.ist   = is_store;
            st_d.iaddr = addr_c;
            st_d.idata = wdata_c;
            st_d.itime = st_q.cyc;
            if (is_store) begin
                st_d.sval = st_q.sval + DATA_W'(NUM_INST);
            end
        end

        if (hit) begin
            st_d.rv    = 1'b1;
            st_d.rid   = hit_id;
            st_d.rdata = rsp_data;
            st_d.rtime = st_q.cyc;
        end

        if (expired) begin
            st_d.err = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign req_valid     = offer;
    assign req_tag       = cur_tag;
    assign req_store     = is_store;
    assign req_addr      = addr_c;
    assign req_wdata     = wdata_c;
    assign iss_rec_valid = st_q.iv;
    assign iss_rec_id    = st_q.iid;
    assign iss_rec_store = st_q.ist;
    assign iss_rec_addr  = st_q.iaddr;
    assign iss_rec_data  = st_q.idata;
    assign iss_rec_time  = st_q.itime;
    assign rsp_rec_valid = st_q.rv;
    assign rsp_rec_id    = st_q.rid;
    assign rsp_rec_data  = st_q.rdata;
    assign rsp_rec_time  = st_q.rtime;
    assign rec_core      = CORE_W'(INST_ID);
    assign timeout_err   = st_q.err;
    assign done          = st_q.fin;

endmodule

// File: rtl/memtrace_gen_chk.sv
module memtrace_gen_chk #(
    parameter int INST_ID  = 0,
    parameter int NUM_INST = 2,
    parameter int TAG_W    = 2,
    parameter int ADDR_W   = 32,
    parameter int DATA_W   = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [TAG_W-1:0]  req_tag,
    input logic              req_store,
    input logic [ADDR_W-1:0] req_addr,
    input logic [DATA_W-1:0] req_wdata,
    input logic              rsp_valid,
    input logic              iss_rec_valid,
    input logic              rsp_rec_valid,
    input logic              timeout_err,
    input logic              done
);

    // R3: an offered request holds still until accepted
    assert_hold_offer_R3: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ready |=> req_valid && $stable(req_tag) && $stable(req_addr)
                                    && $stable(req_wdata) && $stable(req_store));

    // R4: store values belong to this instance's residue class
    assert_store_value_R4: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_store |-> (req_wdata % DATA_W'(NUM_INST)) == DATA_W'(INST_ID));

    // R4: loads carry no data
    assert_load_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_store |-> req_wdata == '0);

    // R6: an issue record only follows a handshake
    assert_issue_record_R6: assert property (@(posedge clk) disable iff (!rst_n)
        iss_rec_valid |-> $past(req_valid && req_ready));

    // R7: a response record only follows a response
    assert_response_record_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_rec_valid |-> $past(rsp_valid));

    // R9: timeout flag is sticky
    assert_timeout_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_err |=> timeout_err);

    // R10: nothing is offered once the run is complete
    assert_done_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !req_valid);

endmodule

bind memtrace_gen memtrace_gen_chk #(
    .INST_ID  (INST_ID),
    .NUM_INST (NUM_INST),
    .TAG_W    (TAG_W),
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_tag       (req_tag),
    .req_store     (req_store),
    .req_addr      (req_addr),
    .req_wdata     (req_wdata),
    .rsp_valid     (rsp_valid),
    .iss_rec_valid (iss_rec_valid),
    .rsp_rec_valid (rsp_rec_valid),
    .timeout_err   (timeout_err),
    .done          (done)
);

// File: tb/memtrace_gen_tb.sv
module memtrace_gen_tb;

    localparam int INST_ID     = 1;
    localparam int NUM_INST    = 3;
    localparam int NUM_OPS     = 24;
    localparam int TAG_W       = 2;
    localparam int POOL_W      = 2;
    localparam int ADDR_STRIDE = 8;
    localparam int ADDR_W      = 32;
    localparam int DATA_W      = 32;
    localparam int TS_W        = 32;
    localparam int TIMEOUT     = 20;
    localparam int OPS_W       = $clog2(NUM_OPS + 1);
    localparam int CORE_W      = 2;
    localparam int NSLOT       = 1 << TAG_W;
    localparam int NVEC        = 5;

    // {seed, ready pattern, respond-newest-first}
    localparam logic [40:0] VECS [NVEC] = '{
        {32'h0000_0001, 8'hFF, 1'b0},
        {32'hDEAD_BEEF, 8'hB6, 1'b1},
        {32'h0000_0000, 8'h5A, 1'b0},
        {32'h1357_9BDF, 8'hFF, 1'b1},
        {32'hC0FF_EE01, 8'h93, 1'b0}
    };

    logic              clk;
    logic              rst_n;
    logic              start;
    logic [31:0]       seed_in;
    logic              req_valid;
    logic              req_ready;
    logic [TAG_W-1:0]  req_tag;
    logic              req_store;
    logic [ADDR_W-1:0] req_addr;
    logic [DATA_W-1:0] req_wdata;
    logic              rsp_valid;
    logic [TAG_W-1:0]  rsp_tag;
    logic [DATA_W-1:0] rsp_data;
    logic              iss_rec_valid;
    logic [OPS_W-1:0]  iss_rec_id;
    logic              iss_rec_store;
    logic [ADDR_W-1:0] iss_rec_addr;
    logic [DATA_W-1:0] iss_rec_data;
    logic [TS_W-1:0]   iss_rec_time;
    logic              rsp_rec_valid;
    logic [OPS_W-1:0]  rsp_rec_id;
    logic [DATA_W-1:0] rsp_rec_data;
    logic [TS_W-1:0]   rsp_rec_time;
    logic [CORE_W-1:0] rec_core;
    logic              timeout_err;
    logic              done;

    memtrace_gen #(
        .INST_ID     (INST_ID),
        .NUM_INST    (NUM_INST),
        .NUM_OPS     (NUM_OPS),
        .TAG_W       (TAG_W),
        .POOL_W      (POOL_W),
        .ADDR_STRIDE (ADDR_STRIDE),
        .ADDR_W      (ADDR_W),
        .DATA_W      (DATA_W),
        .TS_W        (TS_W),
        .TIMEOUT     (TIMEOUT)
    ) u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .start         (start),
        .seed          (seed_in),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_tag       (req_tag),
        .req_store     (req_store),
        .req_addr      (req_addr),
        .req_wdata     (req_wdata),
        .rsp_valid     (rsp_valid),
        .rsp_tag       (rsp_tag),
        .rsp_data      (rsp_data),
        .iss_rec_valid (iss_rec_valid),
        .iss_rec_id    (iss_rec_id),
        .iss_rec_store (iss_rec_store),
        .iss_rec_addr  (iss_rec_addr),
        .iss_rec_data  (iss_rec_data),
        .iss_rec_time  (iss_rec_time),
        .rsp_rec_valid (rsp_rec_valid),
        .rsp_rec_id    (rsp_rec_id),
        .rsp_rec_data  (rsp_rec_data),
        .rsp_rec_time  (rsp_rec_time),
        .rec_core      (rec_core),
        .timeout_err   (timeout_err),
        .done          (done)
    );

    int n_chk  = 0;
    int n_fail = 0;
    int n_ooo  = 0;
    int wd     = 0;
    logic [31:0] bcyc;

    initial clk = 1'b0;
    always #5 clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) bcyc <= '0;
        else        bcyc <= bcyc + 1;
    end

    always @(posedge clk) begin
        wd++;
        if (wd == 150000) begin
            n_fail++;
            $display("FAIL watchdog (R10 run completion): actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // independent model of the operation sequence
    logic        ex_st   [NUM_OPS];
    logic [31:0] ex_addr [NUM_OPS];
    logic [31:0] ex_wd   [NUM_OPS];
    logic        ex_fn   [NUM_OPS];
    int          ex_n;

    task automatic build_model(input logic [31:0] sd);
        logic [31:0] l;
        int sc;
        bit fp;
        l = (sd == 32'h0) ? 32'h1 : sd;
        sc = 0; fp = 0; ex_n = 0;
        for (int i = 0; i < NUM_OPS; i++) begin
            if (l[1:0] == 2'd3) begin
                fp = 1;
            end else begin
                ex_st[ex_n]   = (l[1:0] == 2'd2);
                ex_addr[ex_n] = {30'd0, l[3:2]} * ADDR_STRIDE;
                ex_wd[ex_n]   = ex_st[ex_n] ? 32'(INST_ID + (sc + 1) * NUM_INST) : 32'h0;
                if (ex_st[ex_n]) sc++;
                ex_fn[ex_n] = fp;
                fp = 0;
                ex_n++;
            end
            l = (l >> 1) ^ (l[0] ? 32'h8020_0003 : 32'h0);
        end
    endtask

    task automatic run_vec(input logic [40:0] v);
        logic [31:0] sd;
        logic [7:0]  rmask;
        bit          alt, hs, pi, pr, tag_busy, ok_run;
        int          k, on, wt, idx;
        int          o_tag [NSLOT];
        int          o_id  [NSLOT];
        int          pi_id, pr_id;
        logic        pi_st;
        logic [31:0] pi_addr, pi_wd, pi_t, pr_d, pr_t;
        sd = v[40:9]; rmask = v[8:1]; alt = v[0];
        build_model(sd);
        k = 0; on = 0; wt = 0; pi = 0; pr = 0; ok_run = 0;
        pi_id = 0; pr_id = 0; pi_st = 0; pi_addr = 0; pi_wd = 0; pi_t = 0; pr_d = 0; pr_t = 0;
        seed_in = sd;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int cyc = 0; cyc < 3000; cyc++) begin
            chk("R6", "issue record valid", iss_rec_valid, pi);
            if (pi && iss_rec_valid) begin
                chk("R6", "issue record id", iss_rec_id, pi_id);
                chk("R2", "issue record kind", iss_rec_store, pi_st);
                chk("R2", "issue record address", iss_rec_addr, pi_addr);
                chk("R4", "issue record data", iss_rec_data, pi_wd);
                chk("R6", "issue record time", iss_rec_time, pi_t);
            end
            chk("R7", "response record valid", rsp_rec_valid, pr);
            if (pr && rsp_rec_valid) begin
                chk("R7", "response record id", rsp_rec_id, pr_id);
                chk("R7", "response record data", rsp_rec_data, pr_d);
                chk("R7", "response record time", rsp_rec_time, pr_t);
            end
            if (done) begin
                ok_run = 1;
                break;
            end
            req_ready = rmask[cyc % 8];
            hs = req_valid && req_ready;
            pi = 0;
            if (hs) begin
                if (k < ex_n) begin
                    chk("R1", "request sequence store flag", req_store, ex_st[k]);
                    chk("R2", "request address", req_addr, ex_addr[k]);
                    chk("R4", "store value", req_wdata, ex_wd[k]);
                    chk("R3", "tag from request number", req_tag, k % NSLOT);
                    tag_busy = 0;
                    for (int j = 0; j < on; j++) if (o_tag[j] == int'(req_tag)) tag_busy = 1;
                    chk("R3", "tag offered while outstanding", tag_busy, 0);
                    if (ex_fn[k]) chk("R5", "outstanding at post-fence issue", on, 0);
                    pi = 1; pi_id = k; pi_st = ex_st[k]; pi_addr = ex_addr[k];
                    pi_wd = ex_wd[k]; pi_t = bcyc;
                end else begin
                    chk("R10", "request beyond operation count", k, ex_n);
                end
            end
            rsp_valid = 1'b0;
            pr = 0;
            if (on > 0) begin
                wt++;
                if (on >= 2 || wt >= 3) begin
                    idx = alt ? on - 1 : 0;
                    if (idx != 0) n_ooo++;
                    alt = !alt;
                    wt = 0;
                    rsp_valid = 1'b1;
                    rsp_tag   = TAG_W'(o_tag[idx]);
                    rsp_data  = 32'hA500_0000 + 32'(o_id[idx] * 5);
                    pr = 1; pr_id = o_id[idx]; pr_d = rsp_data; pr_t = bcyc;
                    for (int j = idx; j < on - 1; j++) begin
                        o_tag[j] = o_tag[j + 1];
                        o_id[j]  = o_id[j + 1];
                    end
                    on--;
                end
            end
            if (hs && k < ex_n) begin
                o_tag[on] = k % NSLOT;
                o_id[on]  = k;
                on++;
                k++;
            end
            @(negedge clk);
        end
        req_ready = 1'b0;
        rsp_valid = 1'b0;
        chk("R10", "done at end of run", ok_run, 1);
        chk("R1", "requests issued for seed", k, ex_n);
        chk("R10", "outstanding when done", on, 0);
        chk("R9", "no timeout in normal run", timeout_err, 0);
    endtask

    initial begin
        logic [31:0] h;
        logic [TAG_W-1:0] t;
        bit got;
        rst_n = 1'b0; start = 1'b0; seed_in = '0; req_ready = 1'b0;
        rsp_valid = 1'b0; rsp_tag = '0; rsp_data = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state
        chk("R10", "done after reset", done, 0);
        chk("R3", "req_valid after reset", req_valid, 0);
        chk("R9", "timeout after reset", timeout_err, 0);
        chk("R6", "issue record after reset", iss_rec_valid, 0);
        chk("R7", "response record after reset", rsp_rec_valid, 0);
        chk("R11", "core number", rec_core, INST_ID);

        // R8: a response in idle produces no record
        rsp_valid = 1'b1; rsp_tag = 2'd1; rsp_data = 32'h55;
        @(negedge clk);
        rsp_valid = 1'b0;
        chk("R8", "idle response ignored", rsp_rec_valid, 0);

        // table of seeds and handshake patterns (R1, seed 0 behaves as seed 1)
        for (int vi = 0; vi < NVEC; vi++) begin
            run_vec(VECS[vi]);
        end
        chk("R7", "out-of-order responses exercised", n_ooo > 0, 1);
        chk("R11", "core number after runs", rec_core, INST_ID);

        // directed: stray response and timeout
        seed_in = 32'h2468_ACE1;
        req_ready = 1'b1;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        got = 0; h = 0; t = '0;
        for (int i = 0; i < 64 && !got; i++) begin
            if (req_valid) begin
                got = 1; h = bcyc; t = req_tag;
            end
            @(negedge clk);
        end
        chk("R10", "done cleared by new run", done, 0);
        chk("R3", "first request tag", t, 0);
        req_ready = 1'b0;
        rsp_valid = 1'b1; rsp_tag = t + 1'b1; rsp_data = 32'h77;
        @(negedge clk);
        rsp_valid = 1'b0;
        chk("R8", "stray tag ignored", rsp_rec_valid, 0);
        while (bcyc < h + TIMEOUT) @(negedge clk);
        chk("R9", "timeout one edge early", timeout_err, 0);
        @(negedge clk);
        chk("R9", "timeout at limit", timeout_err, 1);
        rsp_valid = 1'b1; rsp_tag = t; rsp_data = 32'h99;
        @(negedge clk);
        rsp_valid = 1'b0;
        chk("R7", "late response still recorded", rsp_rec_valid, 1);
        repeat (3) @(negedge clk);
        chk("R9", "timeout sticky", timeout_err, 1);

        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9", "timeout cleared by reset", timeout_err, 0);
        chk("R10", "done after second reset", done, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule